// File: doc/BRIEF.md
# Three-Dimensional DMA Address Sequencer

This block produces the pair of byte-address streams that a DMA engine follows when it copies a region shaped as frames of arrays of bytes. A transfer is described by three counts: bytes per array, arrays per frame and frames per transfer. It also takes a base address and two signed strides for each side. One stride is the distance between the starts of neighbouring arrays, and the other is the distance between the starts of neighbouring frames. Source and destination have their own strides. Because of this, a scattered two-dimensional region can be gathered into a dense buffer, or a dense buffer can be scattered back into a region.

A single-cycle `start` latches the packed parameter words and the two bases. From the next cycle on, the block presents one address pair per clock until the transfer is finished. A beat carries one byte. It carries a whole bus word instead when enough bytes remain in the current array and both addresses are word-aligned. One cycle after the final beat, `done` pulses and `busy` drops. Moving the data and storing the parameter sets are left to the surrounding engine.

Top module: `dma3d_addr_seq`

## Requirements
- R1: After reset, `busy`, `beat_valid`, `beat_wide` and `done` are all low.
- R2: The count word carries the arrays-per-frame count in bits 31:16 and the bytes-per-array count in bits 15:0. The frame count is a separate 16-bit input, and a value of 1 means one frame.
- R3: Each stride word carries the destination stride in bits 31:16 and the source stride in bits 15:0. This layout is used for both the array-stride word and the frame-stride word. Every stride is a 16-bit two's-complement value that is sign-extended before it is added.
- R4: The beat at byte offset a of array b in frame c presents address base + b·(array stride) + c·(frame stride) + a on each side. Byte offsets are walked first, then arrays, then frames.
- R5: A beat is wide (4 bytes, `beat_wide` high) exactly when at least 4 bytes remain in the current array and both the source and destination addresses have bits 1:0 equal to zero. Otherwise the beat moves 1 byte. The byte offset advances by the size of the beat.
- R6: While `busy` is high, `beat_valid` is high and exactly one beat is issued per clock. The first beat appears in the cycle after `start` is accepted.
- R7: `done` is high for exactly one cycle, in the cycle after the last beat. In that cycle `busy` and `beat_valid` are already low.
- R8: If any of the three counts is zero, no beat is issued and `done` pulses in the cycle after `start`.
- R9: A `start` received while `busy` is high is ignored. Changes to the parameter inputs during a transfer do not alter the beats of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle request to begin a transfer; ignored while busy |
| count_word | input | 32 | Arrays per frame in the upper half, bytes per array in the lower half |
| frame_count | input | 16 | Number of frames |
| array_idx_word | input | 32 | Signed array strides: destination upper half, source lower half |
| frame_idx_word | input | 32 | Signed frame strides: destination upper half, source lower half |
| src_base | input | ADDR_W | Source start address |
| dst_base | input | ADDR_W | Destination start address |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_src | output | ADDR_W | Source byte address of the beat |
| beat_dst | output | ADDR_W | Destination byte address of the beat |
| beat_wide | output | 1 | Beat moves a full 4-byte word instead of one byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer, including an empty one, has finished |

## Verification
The assertions check the following on every cycle: a wide beat is never issued at a misaligned address, `done` never coincides with an active beat, `busy` never falls without `done`, an empty request finishes at once without beats, the first beat sits at the latched bases, and a start received mid-transfer never drops `busy` early. Only the bench scenarios can show that the full beat sequence matches the stride formula, with its field packing and sign extension. The same holds for the switch from byte beats to word beats at unaligned starts and array tails, and for ignoring parameter changes during a transfer. For these, the bench compares every beat against the closed-form address computed from the counters.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;
    localparam int CNT_W = 16;

    typedef struct packed {
        logic [CNT_W-1:0] acnt;
        logic [CNT_W-1:0] bcnt;
        logic [CNT_W-1:0] ccnt;
    } xfer_cnt_t;
endpackage

// File: rtl/dma3d_param_unpack.sv
module dma3d_param_unpack
    import dma3d_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [31:0]       count_word,
    input  logic [CNT_W-1:0]  frame_count,
    input  logic [31:0]       array_idx_word,
    input  logic [31:0]       frame_idx_word,
    output xfer_cnt_t         cnt,
    output logic [ADDR_W-1:0] src_astride,
    output logic [ADDR_W-1:0] dst_astride,
    output logic [ADDR_W-1:0] src_fstride,
    output logic [ADDR_W-1:0] dst_fstride,
    output logic              empty
);
    localparam int EXT_W = ADDR_W - 16;

    always_comb begin
        cnt.acnt    = count_word[15:0];
        cnt.bcnt    = count_word[31:16];
        cnt.ccnt    = frame_count;
        // R3: destination in the upper half, source in the lower half, sign-extended
        src_astride = {{EXT_W{array_idx_word[15]}}, array_idx_word[15:0]};
        dst_astride = {{EXT_W{array_idx_word[31]}}, array_idx_word[31:16]};
        src_fstride = {{EXT_W{frame_idx_word[15]}}, frame_idx_word[15:0]};
        dst_fstride = {{EXT_W{frame_idx_word[31]}}, frame_idx_word[31:16]};
        empty       = (cnt.acnt == '0) || (cnt.bcnt == '0) || (cnt.ccnt == '0);
    end
endmodule

// File: rtl/dma3d_beat_size.sv
module dma3d_beat_size
    import dma3d_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    localparam int AL_W = $clog2(WORD_BYTES)
) (
    input  logic [CNT_W-1:0] remaining,
    input  logic [AL_W-1:0]  src_lo,
    input  logic [AL_W-1:0]  dst_lo,
    output logic             wide,
    output logic [CNT_W-1:0] step
);
    always_comb begin
        wide = (remaining >= CNT_W'(WORD_BYTES)) && (src_lo == '0) && (dst_lo == '0);
        step = wide ? CNT_W'(WORD_BYTES) : CNT_W'(1);
    end
endmodule

// File: rtl/dma3d_addr_lane.sv
module dma3d_addr_lane
    import dma3d_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] astride,
    input  logic [ADDR_W-1:0] fstride,
    input  logic              next_array,
    input  logic              next_frame,
    input  logic [CNT_W-1:0]  offset,
    output logic [ADDR_W-1:0] addr
);
    typedef struct packed {
        logic [ADDR_W-1:0] arr;
        logic [ADDR_W-1:0] frm;
    } lane_s;

    lane_s l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (load) begin
            l_d.arr = base;
            l_d.frm = base;
        end else if (next_frame) begin
            l_d.frm = l_q.frm + fstride;
            l_d.arr = l_q.frm + fstride;
        end else if (next_array) begin
            l_d.arr = l_q.arr + astride;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign addr = l_q.arr + {{(ADDR_W-CNT_W){1'b0}}, offset};
endmodule

// File: rtl/dma3d_addr_seq.sv
module dma3d_addr_seq
    import dma3d_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       count_word,
    input  logic [15:0]       frame_count,
    input  logic [31:0]       array_idx_word,
    input  logic [31:0]       frame_idx_word,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    output logic              beat_valid,
    output logic [ADDR_W-1:0] beat_src,
    output logic [ADDR_W-1:0] beat_dst,
    output logic              beat_wide,
    output logic              busy,
    output logic              done
);
    localparam int AL_W   = $clog2(WORD_BYTES);
    localparam int NLANES = 2;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [CNT_W-1:0]  aoff;
        logic [CNT_W-1:0]  bidx;
        logic [CNT_W-1:0]  cidx;
        xfer_cnt_t         cnt;
        logic [ADDR_W-1:0] src_as;
        logic [ADDR_W-1:0] dst_as;
        logic [ADDR_W-1:0] src_fs;
        logic [ADDR_W-1:0] dst_fs;
    } seq_s;

    seq_s s_d, s_q;

    xfer_cnt_t         in_cnt;
    logic [ADDR_W-1:0] in_src_as, in_dst_as, in_src_fs, in_dst_fs;
    logic              in_empty;
    logic              load, next_array, next_frame;
    logic              wide;
    logic [CNT_W-1:0]  step, nxt_off;

    logic [ADDR_W-1:0] lane_base [NLANES];
    logic [ADDR_W-1:0] lane_as   [NLANES];
    logic [ADDR_W-1:0] lane_fs   [NLANES];
    logic [ADDR_W-1:0] lane_addr [NLANES];

    dma3d_param_unpack #(.ADDR_W(ADDR_W)) u_unpack (
        .count_word     (count_word),
        .frame_count    (frame_count),
        .array_idx_word (array_idx_word),
        .frame_idx_word (frame_idx_word),
        .cnt            (in_cnt),
        .src_astride    (in_src_as),
        .dst_astride    (in_dst_as),
        .src_fstride    (in_src_fs),
        .dst_fstride    (in_dst_fs),
        .empty          (in_empty)
    );

    always_comb begin
        lane_base[0] = src_base;
        lane_base[1] = dst_base;
        lane_as[0]   = s_q.src_as;
        lane_as[1]   = s_q.dst_as;
        lane_fs[0]   = s_q.src_fs;
        lane_fs[1]   = s_q.dst_fs;
    end

    // Lane 0 walks the source side, lane 1 the destination side.
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        dma3d_addr_lane #(.ADDR_W(ADDR_W)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load),
            .base       (lane_base[g]),
            .astride    (lane_as[g]),
            .fstride    (lane_fs[g]),
            .next_array (next_array),
            .next_frame (next_frame),
            .offset     (s_q.aoff),
            .addr       (lane_addr[g])
        );
    end

    dma3d_beat_size #(.WORD_BYTES(WORD_BYTES)) u_size (
        .remaining (s_q.cnt.acnt - s_q.aoff),
        .src_lo    (lane_addr[0][AL_W-1:0]),
        .dst_lo    (lane_addr[1][AL_W-1:0]),
        .wide      (wide),
        .step      (step)
    );

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        load       = 1'b0;
        next_array = 1'b0;
        next_frame = 1'b0;
        nxt_off    = s_q.aoff + step;
        if (!s_q.busy) begin
            if (start) begin
                s_d.cnt    = in_cnt;
                s_d.src_as = in_src_as;
                s_d.dst_as = in_dst_as;
                s_d.src_fs = in_src_fs;
                s_d.dst_fs = in_dst_fs;
                s_d.aoff   = '0;
                s_d.bidx   = '0;
                s_d.cidx   = '0;
                if (in_empty) begin
                    s_d.done = 1'b1;
                end else begin
                    s_d.busy = 1'b1;
                    load     = 1'b1;
                end
            end
        end else if (nxt_off == s_q.cnt.acnt) begin
            s_d.aoff = '0;
            if (s_q.bidx == s_q.cnt.bcnt - CNT_W'(1)) begin
                s_d.bidx = '0;
                if (s_q.cidx == s_q.cnt.ccnt - CNT_W'(1)) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end else begin
                    s_d.cidx   = s_q.cidx + CNT_W'(1);
                    next_frame = 1'b1;
                end
            end else begin
                s_d.bidx   = s_q.bidx + CNT_W'(1);
                next_array = 1'b1;
            end
        end else begin
            s_d.aoff = nxt_off;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy       = s_q.busy;
    assign done       = s_q.done;
    assign beat_valid = s_q.busy;
    assign beat_wide  = s_q.busy && wide;
    assign beat_src   = lane_addr[0];
    assign beat_dst   = lane_addr[1];
endmodule

// File: rtl/dma3d_addr_seq_chk.sv
module dma3d_addr_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [31:0]       count_word,
    input logic [15:0]       frame_count,
    input logic [ADDR_W-1:0] src_base,
    input logic [ADDR_W-1:0] dst_base,
    input logic              beat_valid,
    input logic [ADDR_W-1:0] beat_src,
    input logic [ADDR_W-1:0] beat_dst,
    input logic              beat_wide,
    input logic              busy,
    input logic              done
);
    logic req_empty;
    assign req_empty = (count_word[15:0] == 16'd0) || (count_word[31:16] == 16'd0)
                     || (frame_count == 16'd0);

    AST_WIDE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_wide |-> (beat_src[1:0] == 2'b00) && (beat_dst[1:0] == 2'b00)); // R5

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !beat_valid); // R7

    AST_END_SIGNALLED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R7

    AST_EMPTY_NO_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && req_empty |=> done && !beat_valid); // R8

    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !req_empty |=> beat_valid && (beat_src == $past(src_base))
                                         && (beat_dst == $past(dst_base))); // R4

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> busy || done); // R9
endmodule

bind dma3d_addr_seq dma3d_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dma3d_addr_seq_bench.sv
`timescale 1ns/1ps
module dma3d_addr_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] count_word = '0;
    logic [15:0] frame_count = '0;
    logic [31:0] array_idx_word = '0;
    logic [31:0] frame_idx_word = '0;
    logic [31:0] src_base = '0;
    logic [31:0] dst_base = '0;
    logic        beat_valid, beat_wide, busy, done;
    logic [31:0] beat_src, beat_dst;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dma3d_addr_seq u_dma3d_addr_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .count_word(count_word), .frame_count(frame_count),
        .array_idx_word(array_idx_word), .frame_idx_word(frame_idx_word),
        .src_base(src_base), .dst_base(dst_base),
        .beat_valid(beat_valid), .beat_src(beat_src), .beat_dst(beat_dst),
        .beat_wide(beat_wide), .busy(busy), .done(done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_addr(input logic [31:0] base, input int b, input int c,
                                             input int a, input logic [15:0] bs, input logic [15:0] cs);
        int sb, sc;
        sb = int'($signed(bs));
        sc = int'($signed(cs));
        return base + 32'(b * sb) + 32'(c * sc) + 32'(a);
    endfunction

    task automatic run_xfer(input int acnt, input int bcnt, input int ccnt,
                            input logic [15:0] s_as, input logic [15:0] d_as,
                            input logic [15:0] s_fs, input logic [15:0] d_fs,
                            input logic [31:0] sb, input logic [31:0] db, input int poke_at);
        int beat;
        @(negedge clk);
        count_word     = {16'(bcnt), 16'(acnt)};
        frame_count    = 16'(ccnt);
        array_idx_word = {d_as, s_as};
        frame_idx_word = {d_fs, s_fs};
        src_base       = sb;
        dst_base       = db;
        start          = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (acnt == 0 || bcnt == 0 || ccnt == 0) begin
            check("R8 empty done/busy/valid", {29'd0, done, busy, beat_valid}, 32'b100);
            @(negedge clk);
            check("R7 done single cycle", {31'd0, done}, 32'd0);
            return;
        end
        beat = 0;
        for (int c = 0; c < ccnt; c++) begin
            for (int b = 0; b < bcnt; b++) begin
                int a;
                a = 0;
                while (a < acnt) begin
                    logic [31:0] es, ed;
                    logic ew;
                    es = exp_addr(sb, b, c, a, s_as, s_fs);
                    ed = exp_addr(db, b, c, a, d_as, d_fs);
                    ew = (acnt - a >= 4) && (es[1:0] == 2'b00) && (ed[1:0] == 2'b00);
                    check("R2/R3/R4 source address", beat_src, es);
                    check("R3/R4 destination address", beat_dst, ed);
                    check("R5/R6 valid and width", {30'd0, beat_valid, beat_wide}, {30'd0, 1'b1, ew});
                    if (beat == poke_at) begin
                        // R9: new request with different parameters mid-transfer
                        start          = 1'b1;
                        count_word     = 32'h0003_0007;
                        array_idx_word = 32'h1111_2222;
                        frame_idx_word = 32'h3333_4444;
                        frame_count    = 16'd5;
                        src_base       = 32'hDEAD_0000;
                        dst_base       = 32'hBEEF_0000;
                    end else begin
                        start = 1'b0;
                    end
                    a += ew ? 4 : 1;
                    beat++;
                    @(negedge clk);
                end
            end
        end
        start = 1'b0;
        check("R7 done after last beat", {29'd0, done, busy, beat_valid}, 32'b100);
        @(negedge clk);
        check("R7 done single cycle", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {28'd0, busy, beat_valid, beat_wide, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {28'd0, busy, beat_valid, beat_wide, done}, 32'd0);

        // R4 R5: gather 12 arrays of 32 bytes, source arrays 0x500 apart, dense destination
        run_xfer(32, 12, 1, 16'h0500, 16'h0020, 16'h0000, 16'h0000, 32'h0001_0000, 32'h0008_0000, -1);
        // R4: linear copy 4x4x1, array strides 4, frame strides 16
        run_xfer(4, 4, 1, 16'h0004, 16'h0004, 16'h0010, 16'h0010, 32'h0000_2000, 32'h0000_3000, -1);
        // R3: negative strides, scatter back over several frames
        run_xfer(8, 3, 2, 16'h0008, 16'hFF00, 16'h0018, 16'hF000, 32'h0000_4000, 32'h0010_0000, -1);
        // R5: differently misaligned bases give byte beats only
        run_xfer(7, 2, 1, 16'h0010, 16'h0010, 16'h0000, 16'h0000, 32'h0000_1001, 32'h0000_2003, -1);
        // R5: equal misalignment gives bytes, then words, then a byte tail
        run_xfer(10, 2, 2, 16'h0040, 16'h0020, 16'h0100, 16'h0200, 32'h0000_5001, 32'h0000_6001, -1);
        // R9: start mid-transfer is ignored
        run_xfer(6, 3, 2, 16'h0020, 16'h0006, 16'h0100, 16'h0012, 32'h0000_7000, 32'h0000_8000, 5);
        // R8: each count zero in turn
        run_xfer(0, 4, 1, 16'h0004, 16'h0004, 16'h0, 16'h0, 32'h100, 32'h200, -1);
        run_xfer(4, 0, 1, 16'h0004, 16'h0004, 16'h0, 16'h0, 32'h100, 32'h200, -1);
        run_xfer(4, 4, 0, 16'h0004, 16'h0004, 16'h0, 16'h0, 32'h100, 32'h200, -1);
        // R2: single byte, single array, single frame
        run_xfer(1, 1, 1, 16'h0000, 16'h0000, 16'h0, 16'h0, 32'h0000_0FFF, 32'h0000_0000, -1);

        for (int i = 0; i < 40; i++) begin
            int acnt, bcnt, ccnt, poke;
            logic [15:0] s_as, d_as, s_fs, d_fs;
            logic [31:0] sb, db;
            acnt = int'($urandom_range(1, 11));
            bcnt = int'($urandom_range(1, 4));
            ccnt = int'($urandom_range(1, 3));
            s_as = 16'(int'($urandom_range(0, 96)) - 48);
            d_as = 16'(int'($urandom_range(0, 96)) - 48);
            s_fs = 16'(int'($urandom_range(0, 512)) - 256);
            d_fs = 16'(int'($urandom_range(0, 512)) - 256);
            sb   = 32'h0004_0000 + 32'($urandom_range(0, 4095));
            db   = 32'h0009_0000 + 32'($urandom_range(0, 4095));
            if ($urandom_range(0, 3) == 0) begin
                sb[1:0] = 2'b00;
                db[1:0] = 2'b00;
            end
            poke = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 3)) : -1;
            run_xfer(acnt, bcnt, ccnt, s_as, d_as, s_fs, d_fs, sb, db, poke);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule